// File: doc/BRIEF.md
# Image Conversion Job Front End

This block is the register-mapped control side of a fixed-function image conversion engine. Software programs a set of job parameter registers (source and destination addresses, strides, chroma and U-plane addresses, output size) over a simple 32-bit write/read port. A write to the configuration register is the launch trigger: it snapshots the current parameters, together with the value written, into a small job queue. Parameter registers may then be reprogrammed for the next job without disturbing queued ones.

A stub back end takes one job at a time from the queue. It runs a number of steps taken from the output-size register, optionally spaced by a throttle gap. In each step it either issues one output write strobe or, in CRC mode, folds one input word address into a running CRC instead of writing. Status reports a completion count, free queue slots, two sticky interrupt flags and a busy bit. An abort control stops the running job and empties the queue. Colour coefficient registers are global and are not part of a job.

Top module: `conv_job_frontend`

## Requirements
- R1: After reset the status register (offset 0x400) reads 0x00000400 (4 free slots in bits 13:8, everything else 0), and both interrupt outputs are low.
- R2: A write to the configuration register (0x408) enqueues a job holding the input address (0x40C), output address (0x41C) and output size (0x420) as they are at that write, plus bit 0 of the written value; later writes to those registers do not alter jobs already queued.
- R3: A job runs N steps, N being bits 7:0 of its output size, with 0 treated as 1; outside CRC mode step k (from 0) raises `out_wr_valid` for one cycle with `out_wr_addr` = output address + 4*k.
- R4: Setup (0x404) bits 1:0, taken at job start, insert 0, 1, 3 or 7 idle cycles between consecutive steps of a job.
- R5: Status bits 23:16 count completed jobs and wrap modulo 256.
- R6: Status bit 0 (busy) is 1 while a job runs or the queue holds a job; status bits 13:8 give 4 minus the number of queued jobs.
- R7: A configuration write while all 4 queue slots are taken is dropped: no job is added and none of its addresses ever appears.
- R8: Writing status with bit 31 set stops the running job, empties the queue, counts no completion and raises no completion interrupt; busy reads 0 and 4 slots free immediately after.
- R9: A finished job whose configuration bit 0 was 1 sets a sticky flag shown on `irq_done` and status bit 1; writing 1 to status bit 1 clears it.
- R10: When setup bits 13:8 are nonzero and the free slot count is at least that value, a sticky flag is set, shown on `irq_slot` and status bit 2; writing 1 to status bit 2 clears it; a threshold of 0 never sets it.
- R11: With setup bit 3 set at job start, the job raises no output write; instead, for each step k, the word (input address + 4*k) is folded into a CRC (reflected polynomial 0xEDB88320, LSB first, no final inversion) started at 0xFFFFFFFF, readable at 0x434.
- R12: With setup bits 3 and 4 both set at job start, the CRC is not reset and continues from the previous job's result.
- R13: `coef_eff` carries the four coefficient registers (0x424..0x430, register 0 in bits 31:0) when bit 31 of coefficient 0 is set, and the parameter DEF_COEF otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| out_wr_valid | output | 1 | Stub output write strobe, one per step |
| out_wr_addr | output | 32 | Address of the stub output write |
| coef_eff | output | 128 | Coefficients in effect |
| irq_done | output | 1 | Sticky completion interrupt |
| irq_slot | output | 1 | Sticky free-slot threshold interrupt |

## Verification
A wrong queue pointer or count shows within one cycle in the free-slot field and busy bit, and as the wrong output addresses once the job is popped. A stuck or misloaded step counter shows as too many or too few write strobes, or a wrong gap between them, within the first job. A wrong CRC reset or chaining decision is visible only on the CRC read after the job ends, so CRC checks compare full results across chained and unchained jobs.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int ADDR_W = 12;
  localparam int STEP_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CS    = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_SETUP = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_CFG   = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_IN    = 12'h40C;
  localparam logic [ADDR_W-1:0] OFF_CHR   = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_STR   = 12'h414;
  localparam logic [ADDR_W-1:0] OFF_UPL   = 12'h418;
  localparam logic [ADDR_W-1:0] OFF_OUT   = 12'h41C;
  localparam logic [ADDR_W-1:0] OFF_SIZE  = 12'h420;
  localparam logic [ADDR_W-1:0] OFF_COEF  = 12'h424;
  localparam logic [ADDR_W-1:0] OFF_CRC   = 12'h434;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic [31:0]       in_addr;
    logic [31:0]       out_addr;
    logic [STEP_W-1:0] steps;
    logic              irq_req;
  } job_t;

  function automatic logic [31:0] crc_fold(input logic [31:0] crc, input logic [31:0] word);
    logic [31:0] c;
    logic        fb;
    c = crc;
    for (int i = 0; i < 32; i++) begin
      fb = c[0] ^ word[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic [2:0] idle_gap(input logic [1:0] thr);
    case (thr)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/conv_job_queue.sv
module conv_job_queue
  import conv_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  job_t             push_data,
  input  logic             pop,
  output job_t             pop_data,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  job_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, push_ok, pop_ok;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign pop_data = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= push_data;
  end

  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count))); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R8
endmodule

// File: rtl/conv_job_engine.sv
module conv_job_engine
  import conv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        abort,
  input  logic        q_empty,
  input  job_t        q_data,
  output logic        q_pop,
  input  logic [1:0]  thr,
  input  logic        crc_en,
  input  logic        crc_chain,
  output logic        out_wr_valid,
  output logic [31:0] out_wr_addr,
  output logic [31:0] crc_value,
  output logic        job_done,
  output logic        job_irq,
  output logic        running
);
  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_GAP} state_t;

  state_t            state;
  job_t              cur;
  logic [STEP_W-1:0] step_idx, last_idx;
  logic [2:0]        gap_cnt;
  logic [1:0]        thr_q;
  logic              crc_mode_q;
  logic              step_fire, last_step;

  assign step_fire = (state == ST_STEP);
  assign last_idx  = (cur.steps == '0) ? '0 : cur.steps - 1'b1;
  assign last_step = (step_idx == last_idx);
  assign q_pop     = (state == ST_IDLE) && !q_empty && !abort;
  assign job_done  = step_fire && last_step && !abort;
  assign job_irq   = job_done && cur.irq_req;
  assign running   = (state != ST_IDLE);

  assign out_wr_valid = step_fire && !crc_mode_q && !abort;
  assign out_wr_addr  = cur.out_addr + (32'(step_idx) << 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur        <= '0;
      step_idx   <= '0;
      gap_cnt    <= '0;
      thr_q      <= '0;
      crc_mode_q <= 1'b0;
      crc_value  <= '1;
    end else begin
      case (state)
        ST_IDLE: if (q_pop) begin
          cur        <= q_data;
          step_idx   <= '0;
          thr_q      <= thr;
          crc_mode_q <= crc_en;
          if (crc_en && !crc_chain) crc_value <= '1;
          state      <= ST_STEP;
        end
        ST_STEP: begin
          if (abort) state <= ST_IDLE;
          else begin
            if (crc_mode_q)
              crc_value <= crc_fold(crc_value, cur.in_addr + (32'(step_idx) << 2));
            if (last_step) state <= ST_IDLE;
            else begin
              step_idx <= step_idx + 1'b1;
              if (idle_gap(thr_q) != 3'd0) begin
                gap_cnt <= idle_gap(thr_q) - 3'd1;
                state   <= ST_GAP;
              end
            end
          end
        end
        default: begin
          if (abort) state <= ST_IDLE;
          else if (gap_cnt == '0) state <= ST_STEP;
          else gap_cnt <= gap_cnt - 3'd1;
        end
      endcase
    end
  end

  AST_THROTTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !last_step && !abort && thr_q != 2'd0) |=> !step_fire); // R4
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !running); // R8
  AST_CRC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !q_pop) |=> $stable(crc_value)); // R12
endmodule

// File: rtl/conv_job_frontend.sv
module conv_job_frontend
  import conv_pkg::*;
#(
  parameter int           QDEPTH   = 4,
  parameter logic [127:0] DEF_COEF = 128'h0198_0000_0066_00D0_0000_0204_0000_012A,
  localparam int          CNT_W    = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              out_wr_valid,
  output logic [31:0]       out_wr_addr,
  output logic [127:0]      coef_eff,
  output logic              irq_done,
  output logic              irq_slot
);
  logic [31:0] setup_q, cfg_q, in_q, chr_q, str_q, upl_q, out_q, size_q;
  logic [31:0] coef_q [4];
  logic [7:0]  done_cnt;
  logic        irq_done_q, irq_slot_q;

  logic             cs_wr, abort, launch, q_pop, q_empty;
  logic             job_done, job_irq, running, busy, slot_cond;
  logic [CNT_W-1:0] q_count;
  logic [5:0]       free_slots, slot_thr;
  logic [31:0]      crc_value;
  job_t             push_job, pop_job;

  assign cs_wr  = bus_wr && (bus_addr == OFF_CS);
  assign abort  = cs_wr && bus_wdata[31];
  assign launch = bus_wr && (bus_addr == OFF_CFG);

  always_comb begin
    push_job.in_addr  = in_q;
    push_job.out_addr = out_q;
    push_job.steps    = size_q[STEP_W-1:0];
    push_job.irq_req  = bus_wdata[0];
  end

  conv_job_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(abort), .push(launch), .push_data(push_job),
    .pop(q_pop), .pop_data(pop_job), .count(q_count), .empty(q_empty)
  );

  conv_job_engine u_engine (
    .clk(clk), .rst_n(rst_n), .abort(abort), .q_empty(q_empty), .q_data(pop_job),
    .q_pop(q_pop), .thr(setup_q[1:0]), .crc_en(setup_q[3]), .crc_chain(setup_q[4]),
    .out_wr_valid(out_wr_valid), .out_wr_addr(out_wr_addr), .crc_value(crc_value),
    .job_done(job_done), .job_irq(job_irq), .running(running)
  );

  assign free_slots = 6'(QDEPTH) - 6'(q_count);
  assign busy       = running || !q_empty;
  assign slot_thr   = setup_q[13:8];
  assign slot_cond  = (slot_thr != '0) && (free_slots >= slot_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_q <= '0; cfg_q <= '0; in_q <= '0; chr_q <= '0;
      str_q   <= '0; upl_q <= '0; out_q <= '0; size_q <= '0;
      done_cnt <= '0; irq_done_q <= 1'b0; irq_slot_q <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          OFF_SETUP: setup_q <= bus_wdata;
          OFF_CFG:   cfg_q   <= bus_wdata;
          OFF_IN:    in_q    <= bus_wdata;
          OFF_CHR:   chr_q   <= bus_wdata;
          OFF_STR:   str_q   <= bus_wdata;
          OFF_UPL:   upl_q   <= bus_wdata;
          OFF_OUT:   out_q   <= bus_wdata;
          OFF_SIZE:  size_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (job_done) done_cnt <= done_cnt + 8'd1;
      if (job_irq) irq_done_q <= 1'b1;
      else if (cs_wr && bus_wdata[1]) irq_done_q <= 1'b0;
      if (slot_cond) irq_slot_q <= 1'b1;
      else if (cs_wr && bus_wdata[2]) irq_slot_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_coef
    always_ff @(posedge clk) begin
      if (!rst_n) coef_q[g] <= '0;
      else if (bus_wr && bus_addr == OFF_COEF + ADDR_W'(4 * g)) coef_q[g] <= bus_wdata;
    end
  end

  assign coef_eff = coef_q[0][31] ? {coef_q[3], coef_q[2], coef_q[1], coef_q[0]} : DEF_COEF;
  assign irq_done = irq_done_q;
  assign irq_slot = irq_slot_q;

  always_comb begin
    case (bus_addr)
      OFF_CS:    bus_rdata = {8'd0, done_cnt, 2'd0, free_slots, 5'd0, irq_slot_q, irq_done_q, busy};
      OFF_SETUP: bus_rdata = setup_q;
      OFF_CFG:   bus_rdata = cfg_q;
      OFF_IN:    bus_rdata = in_q;
      OFF_CHR:   bus_rdata = chr_q;
      OFF_STR:   bus_rdata = str_q;
      OFF_UPL:   bus_rdata = upl_q;
      OFF_OUT:   bus_rdata = out_q;
      OFF_SIZE:  bus_rdata = size_q;
      OFF_COEF:          bus_rdata = coef_q[0];
      OFF_COEF + 12'h4:  bus_rdata = coef_q[1];
      OFF_COEF + 12'h8:  bus_rdata = coef_q[2];
      OFF_COEF + 12'hC:  bus_rdata = coef_q[3];
      OFF_CRC:   bus_rdata = crc_value;
      default:   bus_rdata = '0;
    endcase
  end

  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> (done_cnt == $past(done_cnt) + 8'd1)); // R5
  AST_DONE_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done_q && !(cs_wr && bus_wdata[1])) |=> irq_done_q); // R9
  AST_SLOT_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_slot_q && slot_thr == '0) |=> !irq_slot_q); // R10
  AST_BUSY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots != 6'(QDEPTH)) |-> busy); // R6
endmodule

// File: tb/conv_job_frontend_bench.sv
`timescale 1ns/1ps
module conv_job_frontend_bench;
  localparam logic [127:0] DEF = 128'h0198_0000_0066_00D0_0000_0204_0000_012A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, out_wr_addr;
  logic [127:0] coef_eff;
  logic        out_wr_valid, irq_done, irq_slot;

  int checks = 0, errors = 0, cyc = 0;
  int wr_cnt = 0, first_cyc = -1, last_cyc = -1;
  logic [31:0] wlog [64];
  logic [31:0] crc_model;

  always #2.5 clk = ~clk;

  conv_job_frontend u_conv_job_frontend (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .out_wr_valid(out_wr_valid), .out_wr_addr(out_wr_addr),
    .coef_eff(coef_eff), .irq_done(irq_done), .irq_slot(irq_slot)
  );

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && out_wr_valid) begin
      if (wr_cnt < 64) wlog[wr_cnt] = out_wr_addr;
      if (first_cyc < 0) first_cyc = cyc;
      last_cyc = cyc;
      wr_cnt++;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic clear_log();
    wr_cnt = 0; first_cyc = -1; last_cyc = -1;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(12'h400, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 4; b++) begin
      r = r ^ {24'd0, w[8*b +: 8]};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  task automatic run_job(input logic [31:0] inp, input logic [31:0] outp,
                         input logic [31:0] size, input logic [31:0] cfg);
    wr(12'h40C, inp); wr(12'h41C, outp); wr(12'h420, size);
    clear_log();
    wr(12'h408, cfg);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [31:0] s;
    @(negedge clk); rd(12'h400, s);
    chk("R1 status at reset", s, 32'h400);
    chk("R1 irq_done at reset", irq_done, 0);
    chk("R1 irq_slot at reset", irq_slot, 0);
  endtask

  task automatic t_basic();
    logic [31:0] s;
    wr(12'h404, 0);
    wr(12'h40C, 32'h2000); wr(12'h41C, 32'h1000); wr(12'h420, 3);
    clear_log();
    wr(12'h408, 0);
    rd(12'h400, s);
    chk("R6 busy after launch", s[0], 1);
    wait_idle();
    rd(12'h400, s);
    chk("R3 three writes", wr_cnt, 3);
    chk("R3 addr step0", wlog[0], 32'h1000);
    chk("R3 addr step2", wlog[2], 32'h1008);
    chk("R4 no gap at throttle 0", last_cyc - first_cyc, 2);
    chk("R5 one completion", s[23:16], 1);
    chk("R6 idle and free after job", {s[13:8], s[0]}, {6'd4, 1'b0});
    run_job(0, 32'h3000, 32'h100, 0);
    chk("R3 zero size gives one step", wr_cnt, 1);
    chk("R3 zero size addr", wlog[0], 32'h3000);
  endtask

  task automatic t_throttle();
    for (int t = 1; t < 4; t++) begin
      wr(12'h404, t);
      run_job(0, 32'h4000, 3, 0);
      chk($sformatf("R4 gap throttle %0d", t), last_cyc - first_cyc, 2 * (1 << t));
    end
    wr(12'h404, 0);
  endtask

  task automatic t_queue();
    logic [31:0] s, c0;
    int bad;
    rd(12'h400, c0);
    wr(12'h404, 3);
    wr(12'h41C, 32'h100); wr(12'h420, 40);
    clear_log();
    wr(12'h408, 0);
    repeat (3) @(negedge clk);
    wr(12'h420, 2);
    for (int j = 2; j < 6; j++) begin
      wr(12'h41C, 32'h100 * j);
      wr(12'h408, 0);
    end
    rd(12'h400, s);
    chk("R6 free zero when full", s[13:8], 0);
    wr(12'h41C, 32'h600);
    wr(12'h408, 0);
    wr(12'h41C, 32'h999);
    rd(12'h400, s);
    chk("R7 full push dropped", {s[13:8], s[0]}, {6'd0, 1'b1});
    wait_idle();
    rd(12'h400, s);
    chk("R7 total writes", wr_cnt, 48);
    chk("R5 five completions", s[23:16], c0[23:16] + 8'd5);
    chk("R2 queued snapshot addr", wlog[40], 32'h200);
    chk("R2 last queued job addr", wlog[47], 32'h504);
    bad = 0;
    for (int i = 40; i < 48; i++) if (wlog[i] >= 32'h600) bad++;
    chk("R7 dropped job never ran", bad, 0);
    wr(12'h404, 0);
  endtask

  task automatic t_abort();
    logic [31:0] s, c0;
    int n;
    rd(12'h400, c0);
    wr(12'h404, 3);
    wr(12'h41C, 32'h8000); wr(12'h420, 100);
    clear_log();
    wr(12'h408, 1); wr(12'h408, 1); wr(12'h408, 1);
    repeat (20) @(negedge clk);
    wr(12'h400, 32'h8000_0000);
    rd(12'h400, s);
    chk("R8 status after abort", {s[23:16], s[13:8], s[1], s[0]},
        {c0[23:16], 6'd4, 1'b0, 1'b0});
    n = wr_cnt;
    repeat (50) @(negedge clk);
    chk("R8 no writes after abort", wr_cnt, n);
    chk("R8 no done irq", irq_done, 0);
    wr(12'h404, 0);
  endtask

  task automatic t_done_irq();
    logic [31:0] s;
    run_job(0, 32'h10, 1, 1);
    rd(12'h400, s);
    chk("R9 irq_done set", {irq_done, s[1]}, 2'b11);
    repeat (5) @(negedge clk);
    chk("R9 irq_done sticky", irq_done, 1);
    wr(12'h400, 2);
    chk("R9 irq_done cleared", irq_done, 0);
    run_job(0, 32'h10, 1, 0);
    chk("R9 no irq without request", irq_done, 0);
  endtask

  task automatic t_slot();
    wr(12'h404, 32'h0500);
    repeat (3) @(negedge clk);
    chk("R10 threshold above free", irq_slot, 0);
    wr(12'h404, 32'h0400);
    @(negedge clk);
    chk("R10 threshold met", irq_slot, 1);
    wr(12'h404, 0);
    wr(12'h400, 4);
    repeat (3) @(negedge clk);
    chk("R10 cleared, zero threshold", irq_slot, 0);
  endtask

  task automatic t_crc();
    logic [31:0] s;
    wr(12'h404, 32'h8);
    run_job(32'h40, 32'h9000, 3, 0);
    crc_model = 32'hFFFFFFFF;
    for (int k = 0; k < 3; k++) crc_model = crc_ref(crc_model, 32'h40 + 4 * k);
    rd(12'h434, s);
    chk("R11 no output writes", wr_cnt, 0);
    chk("R11 crc value", s, crc_model);
    wr(12'h404, 32'h18);
    run_job(32'h80, 32'h9000, 2, 0);
    for (int k = 0; k < 2; k++) crc_model = crc_ref(crc_model, 32'h80 + 4 * k);
    rd(12'h434, s);
    chk("R12 chained crc", s, crc_model);
    wr(12'h404, 32'h8);
    run_job(32'h0, 32'h9000, 1, 0);
    rd(12'h434, s);
    chk("R12 unchained crc resets", s, crc_ref(32'hFFFFFFFF, 0));
    wr(12'h404, 0);
  endtask

  task automatic t_coef();
    chk("R13 default coef", coef_eff, DEF);
    wr(12'h428, 32'h11); wr(12'h42C, 32'h22); wr(12'h430, 32'h33);
    wr(12'h424, 32'h12);
    chk("R13 programmed but unselected", coef_eff, DEF);
    wr(12'h424, 32'h8000_0012);
    chk("R13 programmed selected", coef_eff, {32'h33, 32'h22, 32'h11, 32'h8000_0012});
  endtask

  task automatic t_wrap();
    logic [31:0] s, c0;
    rd(12'h400, c0);
    for (int j = 0; j < 256; j++) run_job(0, 0, 1, 0);
    rd(12'h400, s);
    chk("R5 count wraps after 256", s[23:16], c0[23:16]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_throttle();
    t_queue();
    t_abort();
    t_done_irq();
    t_slot();
    t_crc();
    t_coef();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule